// File: doc/BRIEF.md
# Asynchronous Static Memory Sequencer

This block runs single accesses on an external asynchronous memory bus (SRAM, NOR flash or a peripheral behind them) from an internal request/response port. Each access has three phases: setup, strobe and hold. The length of each phase is a 4-bit cycle count. Reads and writes have their own set of counts. Address, bank and byte masks are held steady across all three phases. Write data is driven for the whole write. Read data is sampled at the last edge of the strobe.

Two options change the shape of an access. With wait extension on, a slow device can hold the strobe low through the wait input, which passes through a two-flop synchronizer. With select-strobe on, chip select is low only while the strobe is low. After every access a programmable turnaround gap passes before the next request is accepted. The configuration inputs must stay stable while an access is in flight.

Top module: `amc_top`

## Requirements
- R1: While reset is held, and in the cycle after it, chip select, output enable and write enable are high, the data drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: With wait extension off, a read lasts eff(rd_setup)+eff(rd_strobe)+eff(rd_hold) cycles, counted from the cycle after acceptance up to the cycle before `rsp_valid`. Output enable goes low after eff(rd_setup) cycles and stays low for eff(rd_strobe) cycles. Write enable stays high.
- R3: With wait extension off, a write lasts eff(wr_setup)+eff(wr_strobe)+eff(wr_hold) cycles. Write enable goes low after eff(wr_setup) cycles and stays low for eff(wr_strobe) cycles. Output enable stays high.
- R4: During every cycle of an access, the address, bank and byte-mask outputs equal the values given with the request. The byte masks are active low, one bit per data byte.
- R5: During a write, the data drive enable is high and the data output equals the request data in every access cycle. During a read and during the turnaround gap, the data drive enable is low.
- R6: With select-strobe off, chip select is low in every cycle of the access.
- R7: With select-strobe on, chip select is low in exactly the cycles in which the active strobe is low.
- R8: `rsp_valid` is high for one cycle, in the first cycle after the hold phase. For a read, `rsp_rdata` then holds the bus data sampled in the last strobe cycle.
- R9: With wait extension on, a strobe still low at the end of its count while the synchronized wait input is high stays low. Once the wait input is first sampled low at edge n, the strobe rises at edge n+4. When wait extension is off, a wait input held high does not change the access length.
- R10: The turnaround gap, counted as the number of cycles in which `req_ready` is low starting with the `rsp_valid` cycle, lasts eff(turn) cycles.
- R11: eff(x) is x for x from 1 to 15, and 1 for x = 0. A zero count therefore gives a one-cycle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rd_setup | input | 4 | Read setup count |
| cfg_rd_strobe | input | 4 | Read strobe count |
| cfg_rd_hold | input | 4 | Read hold count |
| cfg_wr_setup | input | 4 | Write setup count |
| cfg_wr_strobe | input | 4 | Write strobe count |
| cfg_wr_hold | input | 4 | Write hold count |
| cfg_turn | input | 4 | Turnaround gap count |
| cfg_wait_en | input | 1 | Enable wait-driven strobe extension |
| cfg_sel_strobe | input | 1 | Chip select follows the strobe |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Idle; a request is taken on valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address |
| req_bank | input | 2 | Bank address |
| req_mask_n | input | 2 | Active-low byte masks |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Access complete pulse |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 22 | External address |
| mem_bank | output | 2 | External bank address |
| mem_mask_n | output | 2 | External byte masks |
| mem_dq_out | output | 16 | Data driven to the bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data read from the bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_wait | input | 1 | Wait request from the device, active high |

## Verification
The hardest case to reach is a wait release that lands on the very edge where the programmed strobe count runs out. A release there must still produce the stretch and then the fixed four-edge release. One edge earlier, the stretch would never start. The bench raises the wait input a few idle cycles before the request so that it has passed the synchronizer. It then counts strobe-low cycles at the pins and drops the wait input after exactly k of them. It uses k equal to the strobe count in directed cases and k up to five beyond it in random ones. The bench also drives a read-data value that changes with every strobe cycle, so a capture one cycle early or late shows up in `rsp_rdata`.

// File: rtl/amc_pkg.sv
// Shared types for the asynchronous memory sequencer.
package amc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_STRETCH,
        PH_TAIL,
        PH_HOLD,
        PH_TURN
    } phase_e;
endpackage

// File: rtl/amc_wait_sync.sv
// Multi-flop synchronizer for the asynchronous wait input.
// Assumes the input may change at any time relative to clk.
module amc_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/amc_sequencer.sv
// Phase sequencer: walks setup, strobe (with optional wait stretch), hold
// and turnaround, each sized by a count where zero acts as one.
// Assumes the configuration is stable while an access is in flight.
module amc_sequencer
    import amc_pkg::*;
#(
    parameter int CW          = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RELEASE_LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_wr,
    input  logic [CW-1:0] rd_setup,
    input  logic [CW-1:0] rd_strobe,
    input  logic [CW-1:0] rd_hold,
    input  logic [CW-1:0] wr_setup,
    input  logic [CW-1:0] wr_strobe,
    input  logic [CW-1:0] wr_hold,
    input  logic [CW-1:0] turn,
    input  logic          wait_en,
    input  logic          wait_s,
    output phase_e        phase,
    output logic          ready,
    output logic          capture,
    output logic          done
);
    localparam logic [CW-1:0] ONE       = CW'(1);
    localparam logic [CW-1:0] TAIL_LOAD = CW'(RELEASE_LAT - SYNC_STAGES - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic          wr_q;
    logic          done_q;
    logic          last;
    logic          stretch_go;
    logic [CW-1:0] strobe_len;
    logic [CW-1:0] hold_len;

    function automatic logic [CW-1:0] eff(input logic [CW-1:0] x);
        return (x == '0) ? ONE : x;
    endfunction

    // Per-access phase lengths and end-of-phase conditions.
    always_comb begin
        last       = (cnt_q == '0);
        stretch_go = wait_en && wait_s;
        strobe_len = eff(wr_q ? wr_strobe : rd_strobe);
        hold_len   = eff(wr_q ? wr_hold : rd_hold);
    end

    // Phase state machine with a shared down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: if (start) begin
                    wr_q    <= start_wr;
                    cnt_q   <= eff(start_wr ? wr_setup : rd_setup) - ONE;
                    phase_q <= PH_SETUP;
                end
                PH_SETUP: if (last) begin
                    cnt_q   <= strobe_len - ONE;
                    phase_q <= PH_STROBE;
                end else cnt_q <= cnt_q - ONE;
                PH_STROBE: if (last) begin
                    if (stretch_go) phase_q <= PH_STRETCH;
                    else begin
                        cnt_q   <= hold_len - ONE;
                        phase_q <= PH_HOLD;
                    end
                end else cnt_q <= cnt_q - ONE;
                PH_STRETCH: if (!wait_s) begin
                    cnt_q   <= TAIL_LOAD;
                    phase_q <= PH_TAIL;
                end
                PH_TAIL: if (last) begin
                    cnt_q   <= hold_len - ONE;
                    phase_q <= PH_HOLD;
                end else cnt_q <= cnt_q - ONE;
                PH_HOLD: if (last) begin
                    cnt_q   <= eff(turn) - ONE;
                    phase_q <= PH_TURN;
                    done_q  <= 1'b1;
                end else cnt_q <= cnt_q - ONE;
                PH_TURN: if (last) phase_q <= PH_IDLE;
                         else      cnt_q   <= cnt_q - ONE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase   = phase_q;
    assign ready   = (phase_q == PH_IDLE);
    assign done    = done_q;
    assign capture = (phase_q == PH_STROBE && last && !stretch_go) ||
                     (phase_q == PH_TAIL && last);

    // R8: completion is a single-cycle pulse.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R10: the first turnaround cycle is the completion cycle.
    a_r10_turn_starts_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_TURN && $past(phase_q) != PH_TURN) |-> done_q);
    // R9: a stretch only happens with wait extension enabled.
    a_r9_stretch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STRETCH) |-> wait_en);
endmodule

// File: rtl/amc_pin_drive.sv
// Pin stage: latches the request, forms the bus strobes from the phase and
// captures read data. Assumes one access at a time, started only when idle.
module amc_pin_drive
    import amc_pkg::*;
#(
    parameter int AW = 22,
    parameter int BW = 2,
    parameter int DW = 16,
    parameter int MW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_wr,
    input  logic [AW-1:0] in_addr,
    input  logic [BW-1:0] in_bank,
    input  logic [MW-1:0] in_mask_n,
    input  logic [DW-1:0] in_wdata,
    input  phase_e        phase,
    input  logic          capture,
    input  logic          sel_strobe,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_o,
    output logic [BW-1:0] bank_o,
    output logic [MW-1:0] mask_n_o,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          cs_n,
    output logic          oe_n,
    output logic          we_n,
    output logic [DW-1:0] rdata
);
    logic [AW-1:0] addr_q;
    logic [BW-1:0] bank_q;
    logic [MW-1:0] mask_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          wr_q;
    logic          in_acc;
    logic          strobe_on;

    // Hold request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            bank_q  <= '0;
            mask_q  <= '1;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (start && phase == PH_IDLE) begin
            addr_q  <= in_addr;
            bank_q  <= in_bank;
            mask_q  <= in_mask_n;
            wdata_q <= in_wdata;
            wr_q    <= start_wr;
        end
    end

    // Sample the bus on the last strobe edge of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (capture && !wr_q) rdata_q <= dq_in;
    end

    // Decode bus controls from the current phase.
    always_comb begin
        in_acc    = (phase == PH_SETUP) || (phase == PH_STROBE) ||
                    (phase == PH_STRETCH) || (phase == PH_TAIL) ||
                    (phase == PH_HOLD);
        strobe_on = (phase == PH_STROBE) || (phase == PH_STRETCH) ||
                    (phase == PH_TAIL);
        cs_n      = sel_strobe ? !strobe_on : !in_acc;
        oe_n      = !(strobe_on && !wr_q);
        we_n      = !(strobe_on && wr_q);
        dq_oe     = in_acc && wr_q;
        mask_n_o  = in_acc ? mask_q : '1;
    end

    assign addr_o = addr_q;
    assign bank_o = bank_q;
    assign dq_out = wdata_q;
    assign rdata  = rdata_q;

    // R5: never drive the data bus while the device may drive it.
    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);
    // R3: read and write strobes are never low together.
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));
    // R4: address and bank stay put through an access.
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (in_acc && $past(in_acc)) |-> ($stable(addr_o) && $stable(bank_o)));
endmodule

// File: rtl/amc_top.sv
// Asynchronous memory access controller top: request port, wait
// synchronizer, phase sequencer and pin stage.
// Assumes configuration inputs change only while req_ready is high.
module amc_top
    import amc_pkg::*;
#(
    parameter int AW          = 22,
    parameter int BW          = 2,
    parameter int DW          = 16,
    parameter int MW          = 2,
    parameter int CW          = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RELEASE_LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_rd_setup,
    input  logic [CW-1:0] cfg_rd_strobe,
    input  logic [CW-1:0] cfg_rd_hold,
    input  logic [CW-1:0] cfg_wr_setup,
    input  logic [CW-1:0] cfg_wr_strobe,
    input  logic [CW-1:0] cfg_wr_hold,
    input  logic [CW-1:0] cfg_turn,
    input  logic          cfg_wait_en,
    input  logic          cfg_sel_strobe,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [BW-1:0] req_bank,
    input  logic [MW-1:0] req_mask_n,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [BW-1:0] mem_bank,
    output logic [MW-1:0] mem_mask_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    input  logic          mem_wait
);
    phase_e phase;
    logic   wait_s;
    logic   capture;
    logic   start;

    assign start = req_valid && req_ready;

    amc_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(mem_wait), .dout(wait_s)
    );

    amc_sequencer #(.CW(CW), .SYNC_STAGES(SYNC_STAGES), .RELEASE_LAT(RELEASE_LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_wr(req_write),
        .rd_setup(cfg_rd_setup), .rd_strobe(cfg_rd_strobe), .rd_hold(cfg_rd_hold),
        .wr_setup(cfg_wr_setup), .wr_strobe(cfg_wr_strobe), .wr_hold(cfg_wr_hold),
        .turn(cfg_turn), .wait_en(cfg_wait_en), .wait_s(wait_s),
        .phase(phase), .ready(req_ready), .capture(capture), .done(rsp_valid)
    );

    amc_pin_drive #(.AW(AW), .BW(BW), .DW(DW), .MW(MW)) u_pins (
        .clk(clk), .rst_n(rst_n), .start(start), .start_wr(req_write),
        .in_addr(req_addr), .in_bank(req_bank), .in_mask_n(req_mask_n),
        .in_wdata(req_wdata), .phase(phase), .capture(capture),
        .sel_strobe(cfg_sel_strobe), .dq_in(mem_dq_in),
        .addr_o(mem_addr), .bank_o(mem_bank), .mask_n_o(mem_mask_n),
        .dq_out(mem_dq_out), .dq_oe(mem_dq_oe), .cs_n(mem_cs_n),
        .oe_n(mem_oe_n), .we_n(mem_we_n), .rdata(rsp_rdata)
    );

    // R7: in select-strobe mode chip select is low only under a strobe.
    a_r7_sel_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel_strobe && !mem_cs_n) |-> (!mem_oe_n || !mem_we_n));
    // R1: no strobe or data drive while idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_oe_n && mem_we_n && !mem_dq_oe));
endmodule

// File: tb/amc_top_bench.sv
`timescale 1ns/1ps
module amc_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_su = 4'd1, rd_st = 4'd1, rd_ho = 4'd1;
    logic [3:0]  wr_su = 4'd1, wr_st = 4'd1, wr_ho = 4'd1, turn = 4'd1;
    logic        wait_en = 1'b0, sel_strobe = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [1:0]  req_bank = '0, req_mask_n = 2'b11;
    logic [15:0] req_wdata = '0, mem_dq_in = '0;
    logic        mem_wait = 1'b0;
    logic        req_ready, rsp_valid, mem_dq_oe, mem_cs_n, mem_oe_n, mem_we_n;
    logic [15:0] rsp_rdata, mem_dq_out;
    logic [21:0] mem_addr;
    logic [1:0]  mem_bank, mem_mask_n;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    amc_top u_amc_top (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_setup(rd_su), .cfg_rd_strobe(rd_st), .cfg_rd_hold(rd_ho),
        .cfg_wr_setup(wr_su), .cfg_wr_strobe(wr_st), .cfg_wr_hold(wr_ho),
        .cfg_turn(turn), .cfg_wait_en(wait_en), .cfg_sel_strobe(sel_strobe),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_bank(req_bank), .req_mask_n(req_mask_n),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_bank(mem_bank), .mem_mask_n(mem_mask_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_wait(mem_wait)
    );

    function automatic int eff(input logic [3:0] x);
        return (x == 4'd0) ? 1 : int'(x);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One access; use_wait holds wait high and drops it after k strobe cycles.
    task automatic run_access(input bit wr, input bit use_wait, input int k);
        logic [21:0] a = 22'($urandom);
        logic [1:0]  b = 2'($urandom);
        logic [1:0]  m = 2'($urandom);
        logic [15:0] wd = 16'($urandom);
        logic [15:0] base = 16'($urandom);
        int su = wr ? eff(wr_su) : eff(rd_su);
        int st = wr ? eff(wr_st) : eff(rd_st);
        int ho = wr ? eff(wr_ho) : eff(rd_ho);
        bit stretch = use_wait && wait_en;
        int exp_st = stretch ? k + 4 : st;
        int idx = 0, first_s = -1, s_cnt = 0, cs_low = 0, cs_mis = 0;
        int field_err = 0, data_err = 0, other_strobe = 0, t = 0, turn_drive = 0;
        if (use_wait) begin
            mem_wait = 1'b1;
            repeat (3) @(negedge clk);
        end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_bank = b;
        req_mask_n = m; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && idx < 400) begin
            logic sl = wr ? !mem_we_n : !mem_oe_n;
            if (sl) begin
                if (first_s < 0) first_s = idx;
                s_cnt++;
                mem_dq_in = base ^ 16'(s_cnt);
                if (stretch && s_cnt == k) mem_wait = 1'b0;
            end
            if (wr ? !mem_oe_n : !mem_we_n) other_strobe++;
            if (!mem_cs_n) cs_low++;
            if (mem_cs_n != !sl) cs_mis++;
            if (mem_addr != a || mem_bank != b || mem_mask_n != m) field_err++;
            if (wr ? (!mem_dq_oe || mem_dq_out != wd) : mem_dq_oe) data_err++;
            idx++;
            @(negedge clk);
        end
        check(idx == su + exp_st + ho, wr ? "R3" : "R2", "access length", idx, su + exp_st + ho);
        check(first_s == su, wr ? "R3" : "R2", "strobe start", first_s, su);
        check(s_cnt == exp_st, stretch ? "R9" : (wr ? "R3" : "R2"), "strobe width", s_cnt, exp_st);
        check(other_strobe == 0, wr ? "R3" : "R2", "wrong strobe cycles", other_strobe, 0);
        check(field_err == 0, "R4", "addr/bank/mask mismatches", field_err, 0);
        check(data_err == 0, "R5", "data drive mismatches", data_err, 0);
        if (sel_strobe) check(cs_mis == 0, "R7", "select vs strobe mismatches", cs_mis, 0);
        else            check(cs_low == idx, "R6", "select low cycles", cs_low, idx);
        if (!wr) check(rsp_rdata == (base ^ 16'(exp_st)), "R8", "read data",
                       int'(rsp_rdata), int'(base ^ 16'(exp_st)));
        @(negedge clk);
        check(!rsp_valid, "R8", "response pulse width", int'(rsp_valid), 0);
        t = 1;
        while (!req_ready && t < 40) begin
            if (mem_dq_oe) turn_drive++;
            t++;
            @(negedge clk);
        end
        check(t == eff(turn), "R10", "turnaround cycles", t, eff(turn));
        check(turn_drive == 0, "R5", "drive during turnaround", turn_drive, 0);
    endtask

    task automatic set_cfg(input int a, input int b, input int c, input int d,
                           input int e, input int f, input int g);
        rd_su = 4'(a); rd_st = 4'(b); rd_ho = 4'(c);
        wr_su = 4'(d); wr_st = 4'(e); wr_ho = 4'(f); turn = 4'(g);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: quiet bus during reset and just after it
        check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid,
              "R1", "reset outputs", 0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid,
              "R1", "post-reset outputs", 0, 1);
        // R2/R3: plain reads and writes
        set_cfg(2, 3, 1, 1, 4, 2, 2);
        run_access(1'b0, 1'b0, 0);
        run_access(1'b1, 1'b0, 0);
        // R11: zero counts act as one
        set_cfg(0, 0, 0, 0, 0, 0, 0);
        run_access(1'b0, 1'b0, 0);
        run_access(1'b1, 1'b0, 0);
        // maximum counts
        set_cfg(15, 15, 15, 15, 15, 15, 15);
        run_access(1'b1, 1'b0, 0);
        // R7: select-strobe mode
        sel_strobe = 1'b1;
        set_cfg(3, 2, 4, 2, 5, 3, 1);
        run_access(1'b0, 1'b0, 0);
        run_access(1'b1, 1'b0, 0);
        sel_strobe = 1'b0;
        // R9: release exactly at the strobe's last edge, and later
        wait_en = 1'b1;
        run_access(1'b0, 1'b1, eff(rd_st));
        run_access(1'b1, 1'b1, eff(wr_st) + 3);
        // R9: wait held high with extension off has no effect
        wait_en = 1'b0;
        mem_wait = 1'b1;
        run_access(1'b0, 1'b1, 0);
        mem_wait = 1'b0;
        // random mix
        for (int i = 0; i < 40; i++) begin
            bit wr = 1'($urandom);
            bit uw = 1'($urandom);
            set_cfg($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                    $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                    $urandom_range(0, 15));
            wait_en = 1'($urandom);
            sel_strobe = 1'($urandom);
            if (!wait_en) mem_wait = 1'b0;
            run_access(wr, uw && wait_en,
                       (wr ? eff(wr_st) : eff(rd_st)) + int'($urandom_range(0, 5)));
            mem_wait = 1'b0;
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule